// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a clocked, single-port memory that behaves at its pins like a pipelined burst SRAM. The address, control and write data are all registered. A cycle can be started by either of two address strobes. One strobe comes from the processor side and always starts a read. The other comes from the controller side and can start either a read or a write. After a cycle has started, a burst-advance input steps a two-bit burst counter through a group of four words, or holds it at the current word. The counter follows a linear or an interleaved order.

Read data comes out one clock after the address is captured. A registered valid flag stands in for a tri-state data bus. A deselect cycle clears the flag on the following edge, so the block has single-cycle deselect. Writes can cover the whole word or any set of 9-bit lanes. The block also has a sleep input, which stops all activity and keeps the stored contents.

The array and lane widths are parameters, so the block can back a cache or a scratch store in a larger chip.

Top module: `burst_sram`

## Requirements
- R1: The chip counts as selected only when `chip_en_n`=0, `chip_sel_n`=0 and `chip_sel`=1. A cycle started by a strobe while the chip is not selected is a deselect cycle.
- R2: A low on `cpu_strobe_n` has no effect while `chip_en_n`=1, and the cycle is decoded as if that strobe were high. A low on `ctl_strobe_n` while `chip_en_n`=1 gives a deselect cycle.
- R3: A cycle started by `cpu_strobe_n` is always a read. The write controls are ignored on that edge.
- R4: A cycle started by `ctl_strobe_n` is a write when `wr_all_n`=0, or when `wr_bytes_n`=0 and at least one bit of `lane_wr_n` is 0. Any other such cycle is a read.
- R5: Lane i is bits [9i+8:9i]. `wr_all_n`=0 writes every lane, whatever `lane_wr_n` holds. With `wr_all_n`=1 and `wr_bytes_n`=0, each lane whose `lane_wr_n` bit is 0 is written. With both inputs high, no lane is written.
- R6: In a cycle with no effective strobe during an active burst, `burst_adv_n`=0 moves to the next burst address and `burst_adv_n`=1 stays on the current one. The write controls then make the cycle a read or a write, as in R4 and R5.
- R7: The two low address bits go through four positions starting from the captured base b. In step n (0..3) the low bits are (b+n) mod 4 when `burst_linear`=1 and b XOR n when `burst_linear`=0. The count wraps back to b, and the upper bits stay fixed.
- R8: For a read captured on edge k, `dout` and `dout_valid`=1 appear on edge k+1. After reset, `dout_valid` is 0.
- R9: `out_en_n`=1 forces `dout_valid` low at once, without waiting for a clock. A write cycle gives `dout_valid`=0 on the following edge.
- R10: While `sleep`=1, the block neither writes nor reads. The array contents are kept. After sleep the block is deselected, and continue cycles do nothing until a strobe starts a new cycle.
- R11: If both strobes are low while `chip_en_n`=0, the processor-side strobe wins and the cycle is a read.
- R12: After a deselect cycle captured on edge k, `dout_valid` is 0 from edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address, captured by a strobe |
| cpu_strobe_n | input | 1 | Processor-side address strobe, active low, read only |
| ctl_strobe_n | input | 1 | Controller-side address strobe, active low |
| burst_adv_n | input | 1 | Burst advance, active low; high holds the burst |
| chip_en_n | input | 1 | Chip enable, active low; also gates the processor-side strobe |
| chip_sel | input | 1 | Chip select, active high |
| chip_sel_n | input | 1 | Chip select, active low |
| wr_all_n | input | 1 | Whole-word write, active low; overrides lane controls |
| wr_bytes_n | input | 1 | Lane-write enable, active low |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| burst_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| sleep | input | 1 | Sleep: freezes activity, keeps contents |
| out_en_n | input | 1 | Output enable, active low, acts without a clock |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data |
| dout_valid | output | 1 | Read data is being driven |

## Verification
Several internal faults show up at the ports as wrong read data. A burst counter that steps wrongly, a wrong order for one mode, or upper address bits that drift all return data from the wrong word, two edges after the cycle that caused it. A wrong write decode shows up as changed or missing lanes in a later read of the same word. A wrong decode of a deselect, sleep or ignored strobe shows up as a wrong state of `dout_valid` on the second edge. It can also show up as a stray write, which is caught by reading back the word the burst pointer was on.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/sbs_cycle_decode.sv
module sbs_cycle_decode
  import sbsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             cpu_n,
  input  logic             ctl_n,
  input  logic             adv_n,
  input  logic             en_n,
  input  logic             sel_hi,
  input  logic             sel_lo_n,
  input  logic             gw_n,
  input  logic             bw_en_n,
  input  logic [LANES-1:0] lane_n,
  input  logic             sleep,
  input  logic             active,
  output logic             load_o,
  output logic             step_o,
  output logic             kill_o,
  output op_e              op_o,
  output logic [LANES-1:0] mask_o
);
  logic             chip_on;
  logic [LANES-1:0] wmask;

  assign chip_on = !en_n && sel_hi && !sel_lo_n;
  assign wmask   = !gw_n ? {LANES{1'b1}} : (!bw_en_n ? ~lane_n : {LANES{1'b0}});

  always_comb begin
    load_o = 1'b0;
    step_o = 1'b0;
    kill_o = 1'b0;
    op_o   = OP_IDLE;
    mask_o = '0;
    if (sleep) begin
      kill_o = 1'b1;
    end else if (!cpu_n && !en_n) begin
      // processor strobe wins over controller strobe, always a read
      if (chip_on) begin
        load_o = 1'b1;
        op_o   = OP_RD;
      end else begin
        kill_o = 1'b1;
      end
    end else if (!ctl_n) begin
      if (chip_on) begin
        load_o = 1'b1;
        mask_o = wmask;
        op_o   = (|wmask) ? OP_WR : OP_RD;
      end else begin
        kill_o = 1'b1;
      end
    end else if (active) begin
      step_o = !adv_n;
      mask_o = wmask;
      op_o   = (|wmask) ? OP_WR : OP_RD;
    end
  end
endmodule

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr #(
  parameter int ADDR_W     = 6,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic              kill,
  input  logic              linear,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              active
);
  localparam int HI_W = ADDR_W - BURST_BITS;

  logic [HI_W-1:0]       hi_q;
  logic [BURST_BITS-1:0] base_q, cnt_q, cnt_nx, low_w;
  logic                  act_q;

  assign cnt_nx = step ? cnt_q + BURST_BITS'(1) : cnt_q;

  always_comb begin
    if (linear) low_w = base_q + cnt_nx;
    else        low_w = base_q ^ cnt_nx;
  end

  assign eff_addr = load ? addr_in : {hi_q, low_w};
  assign active   = act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
    end else if (load) begin
      hi_q   <= addr_in[ADDR_W-1:BURST_BITS];
      base_q <= addr_in[BURST_BITS-1:0];
      cnt_q  <= '0;
      act_q  <= 1'b1;
    end else begin
      if (kill) act_q <= 1'b0;
      cnt_q <= cnt_nx;
    end
  end

  // R7: after the last position the count returns to the base
  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (step && !load && cnt_q == '1) |=> (cnt_q == '0))
    else $error("burst count did not wrap");
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic                      rd,
  input  logic [LANES-1:0]          mask,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  output logic [LANES*LANE_W-1:0]   rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int DW    = LANES * LANE_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int i = 0; i < LANES; i++) begin
        if (mask[i]) mem[addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
      end
    end
    if (rd) rdata <= mem[addr];
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import sbsram_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int LANES      = 4,
  parameter int LANE_W     = 9,
  parameter int BURST_BITS = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     cpu_strobe_n,
  input  logic                     ctl_strobe_n,
  input  logic                     burst_adv_n,
  input  logic                     chip_en_n,
  input  logic                     chip_sel,
  input  logic                     chip_sel_n,
  input  logic                     wr_all_n,
  input  logic                     wr_bytes_n,
  input  logic [LANES-1:0]         lane_wr_n,
  input  logic                     burst_linear,
  input  logic                     sleep,
  input  logic                     out_en_n,
  input  logic [LANES*LANE_W-1:0]  din,
  output logic [LANES*LANE_W-1:0]  dout,
  output logic                     dout_valid
);
  localparam int DW = LANES * LANE_W;

  logic              load_w, step_w, kill_w, active_w;
  op_e               op_w, op_q;
  logic [LANES-1:0]  mask_w, mask_q;
  logic [ADDR_W-1:0] eff_w, addr_q;
  logic [DW-1:0]     din_q;
  logic              drv_q;

  sbs_cycle_decode #(.LANES(LANES)) dec_i (
    .cpu_n(cpu_strobe_n), .ctl_n(ctl_strobe_n), .adv_n(burst_adv_n),
    .en_n(chip_en_n), .sel_hi(chip_sel), .sel_lo_n(chip_sel_n),
    .gw_n(wr_all_n), .bw_en_n(wr_bytes_n), .lane_n(lane_wr_n),
    .sleep(sleep), .active(active_w),
    .load_o(load_w), .step_o(step_w), .kill_o(kill_w),
    .op_o(op_w), .mask_o(mask_w)
  );

  sbs_burst_addr #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) bur_i (
    .clk(clk), .rst(rst), .load(load_w), .step(step_w), .kill(kill_w),
    .linear(burst_linear), .addr_in(addr), .eff_addr(eff_w), .active(active_w)
  );

  // capture stage: one operation per edge
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_IDLE;
      mask_q <= '0;
      drv_q  <= 1'b0;
    end else begin
      op_q   <= op_w;
      mask_q <= mask_w;
      drv_q  <= (op_q == OP_RD);
    end
  end

  always_ff @(posedge clk) begin
    addr_q <= eff_w;
    din_q  <= din;
  end

  sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) mem_i (
    .clk(clk), .we(op_q == OP_WR), .rd(op_q == OP_RD), .mask(mask_q),
    .addr(addr_q), .wdata(din_q), .rdata(dout)
  );

  assign dout_valid = drv_q & ~out_en_n;

  // checker state: port conditions delayed one edge
  logic       sel_ok;
  logic [4:0] watch_q;
  assign sel_ok = !chip_en_n && chip_sel && !chip_sel_n;

  always_ff @(posedge clk) begin
    if (rst) watch_q <= '0;
    else watch_q <= {
      (!sleep && !cpu_strobe_n && !chip_en_n && !chip_sel),
      sleep,
      (!sleep && !ctl_strobe_n && chip_en_n),
      (!sleep && cpu_strobe_n && !ctl_strobe_n && sel_ok && !wr_all_n),
      (!sleep && !cpu_strobe_n && sel_ok)
    };
  end

  p_cpu_read_r3: assert property (@(posedge clk) disable iff (rst)
    watch_q[0] |=> (dout_valid || out_en_n))
    else $error("processor strobe cycle gave no read data");

  p_write_blank_r9: assert property (@(posedge clk) disable iff (rst)
    watch_q[1] |=> !dout_valid)
    else $error("output driven after write cycle");

  p_ctl_desel_r2: assert property (@(posedge clk) disable iff (rst)
    watch_q[2] |=> !dout_valid)
    else $error("controller strobe with enable high did not deselect");

  p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    watch_q[3] |=> !dout_valid)
    else $error("output driven after sleep cycle");

  p_single_desel_r12: assert property (@(posedge clk) disable iff (rst)
    watch_q[4] |=> !dout_valid)
    else $error("deselect did not clear output in one cycle");
endmodule

// File: tb/burst_sram_tb_top.sv
`timescale 1ns/1ps
module burst_sram_tb_top;
  localparam int AW = 6, NL = 4, LW = 9, DW = NL * LW;

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic [AW-1:0] addr = '0;
  logic cpu_n = 1, ctl_n = 1, adv_n = 1, en_n = 1, s_hi = 0, s_lo_n = 1;
  logic gw_n = 1, bwe_n = 1, slp = 0, oe_n = 0, lin = 1;
  logic [NL-1:0] ln = '1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_valid;

  burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW), .BURST_BITS(2)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .cpu_strobe_n(cpu_n), .ctl_strobe_n(ctl_n),
    .burst_adv_n(adv_n), .chip_en_n(en_n), .chip_sel(s_hi), .chip_sel_n(s_lo_n),
    .wr_all_n(gw_n), .wr_bytes_n(bwe_n), .lane_wr_n(ln), .burst_linear(lin),
    .sleep(slp), .out_en_n(oe_n), .din(din), .dout(dout), .dout_valid(dout_valid)
  );

  int checks = 0, fails = 0, negs = 0;
  int        q_due[$];
  logic      q_v[$];
  logic [DW-1:0] q_d[$];
  string     q_tag[$];

  // bench model of the requirements
  logic [DW-1:0] mm [64];
  logic [1:0] m_base = 0, m_cnt = 0;
  logic [3:0] m_hi = 0;
  bit m_act = 0;

  function automatic logic [DW-1:0] pat(int i);
    return DW'(i + 1) * 36'h0_0040_2011 + 36'h1_2345_6789;
  endfunction

  function automatic logic [NL-1:0] wmask(logic gw, logic bwe, logic [NL-1:0] l);
    if (!gw) return '1;
    if (!bwe) return ~l;
    return '0;
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] o, logic [DW-1:0] n, logic [NL-1:0] m);
    logic [DW-1:0] r = o;
    for (int i = 0; i < NL; i++) if (m[i]) r[i*LW +: LW] = n[i*LW +: LW];
    return r;
  endfunction

  function automatic logic [AW-1:0] cur();
    return {m_hi, lin ? 2'(m_base + m_cnt) : (m_base ^ m_cnt)};
  endfunction

  task automatic chk(bit ok, string tag, logic [DW:0] act, logic [DW:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as the design produces results
  always @(negedge clk) begin
    negs++;
    while (q_due.size() > 0 && q_due[0] == negs) begin
      logic ev;
      logic [DW-1:0] ed;
      string tg;
      void'(q_due.pop_front());
      ev = q_v.pop_front() & ~oe_n;
      ed = q_d.pop_front();
      tg = q_tag.pop_front();
      chk((dout_valid == ev) && (!ev || dout == ed), tg, {dout_valid, dout}, {ev, ed});
    end
  end

  task automatic drive(logic c, logic k, logic a, logic e, logic h, logic l,
                       logic g, logic b, logic [NL-1:0] lane, logic [AW-1:0] ad,
                       logic [DW-1:0] d, logic s, logic ev, logic [DW-1:0] ed, string tag);
    @(posedge clk); #2;
    cpu_n = c; ctl_n = k; adv_n = a; en_n = e; s_hi = h; s_lo_n = l;
    gw_n = g; bwe_n = b; ln = lane; addr = ad; din = d; slp = s;
    q_due.push_back(negs + 3); q_v.push_back(ev); q_d.push_back(ed); q_tag.push_back(tag);
  endtask

  task automatic m_start(logic [AW-1:0] a);
    m_hi = a[AW-1:2]; m_base = a[1:0]; m_cnt = 0; m_act = 1;
  endtask

  // processor strobe read (R3, R11): write controls driven active on purpose
  task automatic m_cpu(logic [AW-1:0] a, logic k, logic g, string tag);
    m_start(a);
    drive(0, k, 1, 0, 1, 0, g, 0, '0, a, '1, 0, 1, mm[a], tag);
  endtask

  task automatic m_ctl(logic [AW-1:0] a, logic g, logic b, logic [NL-1:0] l,
                       logic [DW-1:0] d, string tag);
    logic [NL-1:0] m = wmask(g, b, l);
    logic [DW-1:0] ed = mm[a];
    m_start(a);
    if (m != 0) mm[a] = merge(mm[a], d, m);
    drive(1, 0, 1, 0, 1, 0, g, b, l, a, d, 0, (m == 0), ed, tag);
  endtask

  task automatic m_cont(logic c, logic e, logic a, logic g, logic b, logic [NL-1:0] l,
                        logic [DW-1:0] d, string tag);
    logic ev = 0;
    logic [DW-1:0] ed = '0;
    if (m_act) begin
      logic [NL-1:0] m = wmask(g, b, l);
      logic [AW-1:0] ca;
      if (!a) m_cnt = m_cnt + 1;
      ca = cur();
      ed = mm[ca];
      ev = (m == 0);
      if (m != 0) mm[ca] = merge(mm[ca], d, m);
    end
    drive(c, 1, a, e, 1, 0, g, b, l, '1, d, 0, ev, ed, tag);
  endtask

  task automatic m_desel(logic c, logic k, logic e, logic h, logic l, string tag);
    m_act = 0;
    drive(c, k, 1, e, h, l, 1, 1, '1, 6'd2, '0, 0, 0, '0, tag);
  endtask

  task automatic m_sleep(string tag);
    m_act = 0;
    drive(1, 0, 0, 0, 1, 0, 0, 0, '0, 6'd20, 36'h0_DEAD_BEEF, 1, 0, '0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dout_valid == 0, "R8 reset clears valid", {dout_valid, dout}, '0);
    @(posedge clk); #2 rst = 0;

    for (int i = 0; i < 24; i++) m_ctl(AW'(i), 0, 1, '1, pat(i), "R4 whole-word fill");

    lin = 1;
    m_cpu(6, 1, 0, "R3 processor strobe read, GW ignored");
    for (int i = 0; i < 4; i++) m_cont(1, 0, 0, 1, 1, '1, '0, "R7 linear order and wrap");
    m_cont(1, 0, 1, 1, 1, '1, '0, "R6 suspend holds address");
    m_cont(1, 0, 1, 1, 1, '1, '0, "R6 suspend holds address");

    lin = 0;
    m_ctl(9, 1, 1, '1, '0, "R4 controller read");
    for (int i = 0; i < 4; i++) m_cont(1, 0, 0, 1, 1, '1, '0, "R7 interleaved order and wrap");

    m_ctl(3, 1, 0, 4'b1010, 36'hF_FFFF_FFFF, "R5 lane write");
    m_cpu(3, 1, 1, "R5 lanes 0 and 2 merged");
    m_ctl(4, 1, 1, 4'b0000, '0, "R4 R5 both enables high is a read");
    m_cpu(4, 1, 1, "R5 no lane written");
    m_ctl(5, 0, 1, 4'b1111, 36'h0_5555_AAAA, "R5 whole-word overrides lanes");
    m_cpu(5, 1, 1, "R5 whole word readback");

    lin = 1;
    m_cpu(12, 1, 1, "R3 burst start");
    m_cont(1, 0, 1, 0, 1, '1, 36'h1_1111_1111, "R6 write while suspended");
    m_cont(1, 0, 0, 1, 0, 4'b1101, 36'h2_2222_2222, "R6 lane write after advance");
    m_cpu(12, 1, 1, "R6 written word");
    m_cont(1, 0, 0, 1, 1, '1, '0, "R6 advanced lane word");

    m_cpu(7, 0, 0, "R11 both strobes give read");
    m_cont(1, 0, 1, 1, 1, '1, '0, "R11 no write happened");
    m_cont(0, 1, 1, 1, 1, '1, '0, "R2 processor strobe ignored with enable high");
    m_desel(1, 0, 1, 1, 0, "R2 controller strobe deselects");
    m_cont(1, 0, 0, 0, 1, '1, 36'h7_7777_7777, "R2 continue after deselect idle");
    m_cpu(4, 1, 1, "R2 no stray write");

    m_cpu(10, 1, 1, "R1 read");
    m_desel(1, 0, 0, 0, 0, "R1 R12 chip_sel low deselects");
    m_cpu(10, 1, 1, "R1 read");
    m_desel(0, 1, 0, 1, 1, "R1 R12 chip_sel_n high deselects");

    m_cpu(11, 1, 1, "R9 read");
    for (int i = 0; i < 3; i++) m_cont(1, 0, 1, 1, 1, '1, '0, "R9 held read");
    @(negedge clk);
    chk(dout_valid == 1, "R9 valid before output enable off", {dout_valid, dout}, {1'b1, mm[11]});
    #1 oe_n = 1;
    #1 chk(dout_valid == 0, "R9 output enable high blanks", {dout_valid, dout}, '0);
    oe_n = 0;
    #1 chk(dout_valid == 1 && dout == mm[11], "R9 output enable restores", {dout_valid, dout}, {1'b1, mm[11]});

    m_ctl(20, 0, 1, '1, 36'h3_3C3C_3C3C, "R10 store");
    m_desel(1, 0, 1, 1, 0, "R10 deselect");
    for (int i = 0; i < 3; i++) m_sleep("R10 sleep no activity");
    m_cont(1, 0, 0, 0, 1, '1, 36'h0_1234_0000, "R10 wake deselected");
    m_cpu(20, 1, 1, "R10 contents retained");
    m_cpu(21, 1, 1, "R10 neighbour untouched");
    m_desel(1, 0, 1, 1, 0, "R12 final deselect");

    repeat (6) @(negedge clk);
    if (q_due.size() != 0) chk(0, "R8 pending items", q_due.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #4_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule